// File: doc/BRIEF.md
# Four-Stage Cascaded Add-Compare-Select Engine

This block computes the forward path metrics of a Viterbi decoder for a shift-register trellis of 16 to 256 states. Four add-compare-select stages are chained, so each accepted set of branch metrics advances the whole trellis by four stages (a radix-16 step). The trellis is split into groups of 16 states that share their low state bits. One group is processed per clock. Metrics live in a ping-pong metric store between groups and between steps.

For every destination state the engine also produces a 4-bit partial-traceback nibble. This nibble is built by register exchange through the four stages. Per state it records the four survivor decisions of the step, so a traceback unit can move back four stages at a time. Branch metric generation and traceback sit outside this block. An upstream unit supplies, for each of the four stages, the metric of each branch label.

Top module: `cascade_acs`

## Requirements
- R1: Each new metric is the larger of (source metric + branch metric) over its two incoming branches. The comparison uses the sign of the 12-bit wrap-around difference. On a tie the branch from the source whose top state bit is 0 wins, and its decision is 0.
- R2: With N states, state s and entering bit u lead to state ((2s)+u) mod N. A branch's label is 2u+p, where p is the top bit of its source state. Stage k's metric for label L is the 6-bit unsigned field bm_data[(4k+L)*6 +: 6], with k=0 the earliest stage.
- R3: One accepted branch-metric word advances every state by exactly four trellis stages. Beat entry j (out_metric[12j +: 12]) holds the metric of state out_base+j.
- R4: Nibble bit k of state d (out_nibble[4d' +: 4] with d' = d - out_base) is the top bit of the survivor's source at stage k, along the survivor path that ends in d.
- R5: A pulse on init loads metric 0 into state 0 and -1024 (12'hC00) into every other state. It also latches the state count as 2^m, with m taken from log_states and clamped to 4..8.
- R6: Each four-stage step produces N/16 output beats, with out_base 0, 16, 32, ... in rising order. out_last is high on the beat with out_base = N-16 and only on that beat.
- R7: bm_ready is high only while the final group of a step is being processed, and never while init is high. Each cycle with bm_valid high processes one group. A cycle with bm_valid low processes nothing, and so gives no beat in the following cycle. bm_data is held for the whole step.
- R8: Outputs are registered. A group processed at one rising edge shows up as a beat (out_valid high) right after that edge. After reset, out_valid is low and the engine is set up as if init had been given with 16 states.
- R9: Metrics from one step are the source metrics of the next step, with no renormalisation between steps.
- R10: init given partway through a step abandons that step. The next step starts from the init metrics at group 0, and no beat appears in the cycle after init.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init | input | 1 | Frame start: load starting metrics and latch the state count |
| log_states | input | 4 | log2 of the state count, sampled on init |
| bm_valid | input | 1 | Branch metrics for the current step are present |
| bm_ready | output | 1 | Final group of the step is being processed this cycle |
| bm_data | input | 96 | Four stages by four labels of 6-bit branch metrics |
| out_valid | output | 1 | A beat of 16 new metrics is present |
| out_last | output | 1 | This beat closes the step |
| out_base | output | 8 | Index of the first state in this beat |
| out_metric | output | 192 | Sixteen 12-bit metrics for states out_base..out_base+15 |
| out_nibble | output | 64 | Sixteen 4-bit partial-traceback nibbles |

## Verification
The assertions check the beat sequencing on every cycle. They cover the rising base order, the placement of out_last after a handshake, the absence of beats after init or in stalled cycles, and bm_ready staying low during init. The arithmetic cannot be seen from sequencing alone. The wrap-around compare, the tie rule, the register-exchange nibbles and the carry of metrics between steps are shown only by the bench. The bench compares every beat against a behavioural forward pass in unbounded integers, across all state counts, random stalls, a clamped size and an abandoned step.

// File: rtl/cascade_acs.sv
module cascade_acs #(
  parameter int MW    = 12,
  parameter int BMW   = 6,
  parameter int LGMAX = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 init,
  input  logic [3:0]           log_states,
  input  logic                 bm_valid,
  output logic                 bm_ready,
  input  logic [16*BMW-1:0]    bm_data,
  output logic                 out_valid,
  output logic                 out_last,
  output logic [LGMAX-1:0]     out_base,
  output logic [16*MW-1:0]     out_metric,
  output logic [63:0]          out_nibble
);
  localparam int NS = 1 << LGMAX;
  localparam int GW = LGMAX - 4;
  localparam logic [MW-1:0] FLOOR = MW'(-(1 << (MW - 2)));

  logic [MW-1:0] mem [2][NS];
  logic          cur;
  logic [GW-1:0] grp;
  logic [3:0]    lg;
  logic [3:0]    lg_in;
  logic [GW-1:0] grp_top;
  logic          last, fire;

  logic [15:0][MW-1:0] sa, sb;
  logic [15:0][3:0]    pa, pb;

  assign lg_in   = (log_states < 4'd4) ? 4'd4 :
                   (log_states > 4'(LGMAX)) ? 4'(LGMAX) : log_states;
  assign grp_top = GW'((1 << (lg - 4'd4)) - 1);
  assign last    = (grp == grp_top);
  assign fire    = bm_valid && !init;
  assign bm_ready = last && !init;

  always_comb begin
    logic [MW-1:0] c0, c1, df;
    for (int x = 0; x < 16; x++) begin
      sa[x] = mem[cur][(LGMAX'(x) << (lg - 4'd4)) | LGMAX'(grp)];
      pa[x] = '0;
    end
    sb = sa;
    pb = pa;
    for (int st = 0; st < 4; st++) begin
      for (int j = 0; j < 16; j++) begin
        c0 = sa[j >> 1]       + MW'(bm_data[(st*4 + (j & 1)*2)     * BMW +: BMW]);
        c1 = sa[(j >> 1) | 8] + MW'(bm_data[(st*4 + (j & 1)*2 + 1) * BMW +: BMW]);
        df = c0 - c1;
        sb[j] = df[MW-1] ? c1 : c0;
        pb[j] = df[MW-1] ? (pa[(j >> 1) | 8] | 4'(1 << st)) : pa[j >> 1];
      end
      sa = sb;
      pa = pb;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur        <= 1'b0;
      grp        <= '0;
      lg         <= 4'd4;
      out_valid  <= 1'b0;
      out_last   <= 1'b0;
      out_base   <= '0;
      out_metric <= '0;
      out_nibble <= '0;
      for (int i = 0; i < NS; i++) mem[0][i] <= (i == 0) ? '0 : FLOOR;
    end else if (init) begin
      lg        <= lg_in;
      grp       <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      for (int i = 0; i < NS; i++) mem[cur][i] <= (i == 0) ? '0 : FLOOR;
    end else begin
      out_valid <= fire;
      out_last  <= fire && last;
      if (fire) begin
        out_base   <= {grp, 4'b0000};
        out_metric <= sa;
        out_nibble <= pa;
        for (int j = 0; j < 16; j++) mem[~cur][{grp, 4'(j)}] <= sa[j];
        if (last) begin
          grp <= '0;
          cur <= ~cur;
        end else begin
          grp <= grp + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cascade_acs_chk.sv
module cascade_acs_chk #(
  parameter int LGMAX = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             init,
  input logic             bm_valid,
  input logic             bm_ready,
  input logic             out_valid,
  input logic             out_last,
  input logic [LGMAX-1:0] out_base
);
  logic [LGMAX:0] nb;

  always_ff @(posedge clk) begin
    if (!rst_n || init) nb <= '0;
    else if (out_valid) nb <= out_last ? '0 : ({1'b0, out_base} + 16);
  end

  a_r7_beat_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(bm_valid && !init));
  a_r7_no_ready_in_init: assert property (@(posedge clk) disable iff (!rst_n)
    init |-> !bm_ready);
  a_r6_last_after_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    (bm_valid && bm_ready && !init) |=> (out_valid && out_last));
  a_r6_last_is_beat: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
  a_r6_base_order: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ({1'b0, out_base} == nb));
  a_r10_init_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> !out_valid);
endmodule

bind cascade_acs cascade_acs_chk #(.LGMAX(LGMAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .init(init), .bm_valid(bm_valid), .bm_ready(bm_ready),
  .out_valid(out_valid), .out_last(out_last), .out_base(out_base)
);

// File: tb/sim_cascade_acs.sv
module sim_cascade_acs;
  localparam int MW = 12, BMW = 6, LGMAX = 8;

  logic clk = 0, rst_n = 0, init = 0, bm_valid = 0;
  logic [3:0] log_states = 4'd4;
  logic [16*BMW-1:0] bm_data = '0;
  logic bm_ready, out_valid, out_last;
  logic [LGMAX-1:0] out_base;
  logic [16*MW-1:0] out_metric;
  logic [63:0] out_nibble;

  cascade_acs #(.MW(MW), .BMW(BMW), .LGMAX(LGMAX)) u0 (
    .clk(clk), .rst_n(rst_n), .init(init), .log_states(log_states),
    .bm_valid(bm_valid), .bm_ready(bm_ready), .bm_data(bm_data),
    .out_valid(out_valid), .out_last(out_last), .out_base(out_base),
    .out_metric(out_metric), .out_nibble(out_nibble));

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  int mdl [256];
  int exm [256];
  int exn [256];
  int bmv [4][4];
  int nst = 16;
  int mon_base = 0;
  string tag = "R1";

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int clampl(int m);
    return (m < 4) ? 4 : (m > 8) ? 8 : m;
  endfunction

  task automatic compute();
    int a [256];
    int b [256];
    int pa [256];
    int pb [256];
    for (int i = 0; i < nst; i++) begin a[i] = mdl[i]; pa[i] = 0; end
    for (int st = 0; st < 4; st++) begin
      for (int ns = 0; ns < nst; ns++) begin
        int p0, p1, u, c0, c1;
        p0 = ns >> 1; p1 = p0 | (nst / 2); u = ns & 1;
        c0 = a[p0] + bmv[st][u*2];
        c1 = a[p1] + bmv[st][u*2 + 1];
        if (c1 > c0) begin b[ns] = c1; pb[ns] = pa[p1] | (1 << st); end
        else begin b[ns] = c0; pb[ns] = pa[p0]; end
      end
      for (int i = 0; i < nst; i++) begin a[i] = b[i]; pa[i] = pb[i]; end
    end
    for (int i = 0; i < nst; i++) begin exm[i] = a[i]; exn[i] = pa[i]; end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      int bm, bn, am, em, an, en;
      bm = -1; bn = -1; am = 0; em = 0; an = 0; en = 0;
      for (int j = 15; j >= 0; j--) begin
        int d;
        d = int'(out_base) + j;
        if (out_metric[j*MW +: MW] != MW'(exm[d])) begin
          bm = j; am = int'(out_metric[j*MW +: MW]); em = exm[d] & 12'hFFF;
        end
        if (int'(out_nibble[j*4 +: 4]) != exn[d]) begin
          bn = j; an = int'(out_nibble[j*4 +: 4]); en = exn[d];
        end
      end
      check(bm < 0, {"R1 ", tag}, "metric", am, em);
      check(bn < 0, "R4", "nibble", an, en);
      check(int'(out_base) == mon_base, "R6", "base", int'(out_base), mon_base);
      check(out_last == (int'(out_base) == nst - 16), "R6", "last", int'(out_last),
            int'(int'(out_base) == nst - 16));
      mon_base = out_last ? 0 : mon_base + 16;
    end
  end

  task automatic do_init(int m);
    @(negedge clk); #1;
    init = 1; log_states = 4'(m); mon_base = 0;
    nst = 1 << clampl(m);
    for (int i = 0; i < 256; i++) mdl[i] = (i == 0) ? 0 : -1024;
    @(negedge clk);
    check(!out_valid, "R10", "beat after init", int'(out_valid), 0);
    check(!bm_ready || !init, "R7", "ready during init", int'(bm_ready), 0);
    #1 init = 0;
  endtask

  task automatic load_bm(int mode);
    for (int st = 0; st < 4; st++)
      for (int l = 0; l < 4; l++) begin
        bmv[st][l] = (mode == 0) ? int'($urandom_range(63)) : (mode == 1) ? 0 : 5;
        bm_data[(st*4 + l)*BMW +: BMW] = BMW'(bmv[st][l]);
      end
    compute();
  endtask

  task automatic run_pass(int stall, int mode);
    bit prev;
    #1;
    load_bm(mode);
    bm_valid = (stall == 0) || ($urandom_range(99) >= stall);
    forever begin
      prev = bm_valid;
      @(negedge clk);
      check(out_valid == prev, "R7", "beat vs valid", int'(out_valid), int'(prev));
      if (prev && out_last) begin
        check(out_valid && out_last, "R8", "closing beat", int'(out_last), 1);
        break;
      end
      bm_valid = (stall == 0) || ($urandom_range(99) >= stall);
    end
    #1 bm_valid = 0;
    for (int i = 0; i < nst; i++) mdl[i] = exm[i];
  endtask

  initial begin
    void'($urandom(32'h5eed_0a11));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!out_valid, "R8", "reset out_valid", int'(out_valid), 0);
    check(bm_ready, "R8", "reset ready with 16 states", int'(bm_ready), 1);

    do_init(4);
    tag = "R5"; run_pass(0, 1);
    tag = "R2"; repeat (5) run_pass(0, 0);
    tag = "R1"; repeat (3) run_pass(0, 2);

    do_init(5);
    tag = "R7"; repeat (4) run_pass(30, 0);

    do_init(8);
    tag = "R3"; repeat (3) run_pass(25, 0);

    do_init(6);
    tag = "R9"; repeat (6) run_pass(0, 0);
    do_init(7);
    repeat (6) run_pass(10, 0);

    do_init(2);
    tag = "R5"; run_pass(0, 0);
    check(nst == 16, "R5", "clamp low", nst, 16);
    do_init(13);
    run_pass(0, 0);

    do_init(8);
    tag = "R10";
    #1 load_bm(0); bm_valid = 1;
    repeat (3) @(negedge clk);
    bm_valid = 0;
    do_init(8);
    run_pass(0, 0);
    run_pass(20, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule